// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and keeps a 64-bit accumulator split into a high word (HI) and a low word (LO). One start strobe begins one operation. The operation is a plain multiply, a multiply-add or a multiply-subtract, and each can treat the operands as signed or unsigned. Software can also load either word directly through two write ports. Both words leave the block sign-extended to a wider output bus.

An operation takes one register stage for the product and a second for the accumulate and write-back. The done flag marks the clock at which HI and LO hold the new result. A start that arrives while a product is still in the stage is dropped. A direct write that collides with the write-back wins, and the whole result of that operation is thrown away.

Top module: `hilo_mac`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, HI, LO and done read zero until something changes them.
- R2: Kind code 0 (and the spare code 3) writes the 64-bit product, bits [31:0] to LO and bits [63:32] to HI.
- R3: With sgn=1 each operand is sign-extended to 64 bits before the multiply. With sgn=0 each operand is zero-extended.
- R4: Kind code 1 writes {HI,LO} + product back to HI and LO, wrapping modulo 2^64.
- R5: Kind code 2 writes {HI,LO} − product back to HI and LO, wrapping modulo 2^64.
- R6: A start sampled at clock edge k changes HI and LO only at edge k+1. done goes high at edge k+1 and low again at edge k+2. At no other time do HI and LO change, except through the direct writes.
- R7: A start sampled at the edge right after an accepted start is ignored: it yields no extra done pulse and no result.
- R8: hi_we or lo_we loads its data word into HI or LO at the next edge. A later accumulate uses the loaded value.
- R9: A direct write sampled at the same edge as a completing operation is applied. The result of that operation is dropped from both words, and done still pulses.
- R10: hi_out and lo_out carry HI and LO sign-extended from bit 31 to OUT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one operation |
| kind | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 multiply |
| sgn | input | 1 | 1 signed operands, 0 unsigned |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| hi_we | input | 1 | Load HI from hi_wdata |
| hi_wdata | input | 32 | Data for HI |
| lo_we | input | 1 | Load LO from lo_wdata |
| lo_wdata | input | 32 | Data for LO |
| hi_out | output | 64 | HI, sign-extended |
| lo_out | output | 64 | LO, sign-extended |
| done | output | 1 | One-cycle completion pulse |

## Verification
Any wrong value in HI or LO shows on hi_out or lo_out at the very next falling edge, because both words are read straight from their registers. A wrong product-stage valid bit shows one edge later, as a missing, doubled or misplaced done pulse. A stale product shows as a wrong accumulate result at the completion edge. A bad collision priority shows as a word that should have held or should have been loaded. The bench compares both words and done against its model on every cycle, so a fault shows up within one or two cycles of its cause.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;
   typedef enum logic [1:0] {
      MAC_MUL  = 2'd0,
      MAC_ADD  = 2'd1,
      MAC_SUB  = 2'd2,
      MAC_MULX = 2'd3
   } mac_kind_e;
endpackage

// File: rtl/hilo_mac_mul.sv
module hilo_mac_mul
   import hilo_mac_pkg::*;
#(
   parameter int W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            sgn,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  mac_kind_e       kind_i,
   output logic            vld,
   output logic [2*W-1:0]  prod,
   output mac_kind_e       kind_q
);
   localparam int PW = 2 * W;

   logic [PW-1:0] a_x;
   logic [PW-1:0] b_x;

   // operand widening: the low PW bits of the product are right for both forms
   always_comb begin
      a_x = sgn ? PW'($signed(a)) : PW'(a);
      b_x = sgn ? PW'($signed(b)) : PW'(b);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         prod   <= '0;
         kind_q <= MAC_MUL;
      end else begin
         vld <= take;
         if (take) begin
            prod   <= a_x * b_x;
            kind_q <= kind_i;
         end
      end
   end
endmodule

// File: rtl/hilo_mac_acc.sv
module hilo_mac_acc
   import hilo_mac_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [2*W-1:0] acc,
   input  logic [2*W-1:0] prod,
   input  mac_kind_e      kind,
   output logic [2*W-1:0] result
);
   always_comb begin
      unique case (kind)
         MAC_ADD: result = acc + prod;
         MAC_SUB: result = acc - prod;
         default: result = prod;
      endcase
   end
endmodule

// File: rtl/hilo_mac_regs.sv
module hilo_mac_regs #(
   parameter int W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit,
   input  logic [2*W-1:0]  result,
   input  logic            hi_we,
   input  logic [W-1:0]    hi_wdata,
   input  logic            lo_we,
   input  logic [W-1:0]    lo_wdata,
   output logic [W-1:0]    hi_q,
   output logic [W-1:0]    lo_q
);
   logic direct;
   assign direct = hi_we | lo_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (direct) begin
         if (hi_we) hi_q <= hi_wdata;
         if (lo_we) lo_q <= lo_wdata;
      end else if (commit) begin
         hi_q <= result[2*W-1:W];
         lo_q <= result[W-1:0];
      end
   end
endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
   import hilo_mac_pkg::*;
#(
   parameter int W     = 32,
   parameter int OUT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        kind,
   input  logic              sgn,
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   input  logic              hi_we,
   input  logic [W-1:0]      hi_wdata,
   input  logic              lo_we,
   input  logic [W-1:0]      lo_wdata,
   output logic [OUT_W-1:0]  hi_out,
   output logic [OUT_W-1:0]  lo_out,
   output logic              done
);
   localparam int AW = 2 * W;

   generate
      if (W < 2) begin : g_bad_w
         $error("hilo_mac: W must be at least 2");
      end
      if (OUT_W < W) begin : g_bad_out
         $error("hilo_mac: OUT_W must not be narrower than W");
      end
   endgenerate

   logic            stage_vld;
   logic            take;
   logic [AW-1:0]   prod;
   mac_kind_e       kind_q;
   logic [AW-1:0]   result;
   logic [W-1:0]    hi_q;
   logic [W-1:0]    lo_q;

   assign take = start & ~stage_vld;

   hilo_mac_mul #(.W(W)) mul_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .sgn    (sgn),
      .a      (a),
      .b      (b),
      .kind_i (mac_kind_e'(kind)),
      .vld    (stage_vld),
      .prod   (prod),
      .kind_q (kind_q)
   );

   hilo_mac_acc #(.W(W)) acc_i (
      .acc    ({hi_q, lo_q}),
      .prod   (prod),
      .kind   (kind_q),
      .result (result)
   );

   hilo_mac_regs #(.W(W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (stage_vld),
      .result   (result),
      .hi_we    (hi_we),
      .hi_wdata (hi_wdata),
      .lo_we    (lo_we),
      .lo_wdata (lo_wdata),
      .hi_q     (hi_q),
      .lo_q     (lo_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= stage_vld;
   end

   generate
      if (OUT_W == W) begin : g_narrow
         assign hi_out = hi_q;
         assign lo_out = lo_q;
      end else begin : g_wide
         assign hi_out = OUT_W'($signed(hi_q));
         assign lo_out = OUT_W'($signed(lo_q));
      end
   endgenerate
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
   parameter int W     = 32,
   parameter int OUT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stage_vld,
   input logic             done,
   input logic             hi_we,
   input logic [W-1:0]     hi_wdata,
   input logic             lo_we,
   input logic [W-1:0]     lo_wdata,
   input logic [OUT_W-1:0] hi_out,
   input logic [OUT_W-1:0] lo_out
);
   AST_START_FILLS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stage_vld) |=> stage_vld); // R6
   AST_STAGE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stage_vld |=> done); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      stage_vld |=> !stage_vld); // R7
   AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hi_we |=> hi_out[W-1:0] == $past(hi_wdata)); // R8
   AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> lo_out[W-1:0] == $past(lo_wdata)); // R8
   AST_COLLIDE_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && hi_we && !lo_we) |=> $stable(lo_out)); // R9
   AST_COLLIDE_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && lo_we && !hi_we) |=> $stable(hi_out)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_vld && !hi_we && !lo_we) |=> ($stable(hi_out) && $stable(lo_out))); // R6
   AST_HI_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      hi_out == OUT_W'($signed(hi_out[W-1:0]))); // R10
   AST_LO_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      lo_out == OUT_W'($signed(lo_out[W-1:0]))); // R10
endmodule

bind hilo_mac hilo_mac_chk #(.W(W), .OUT_W(OUT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .stage_vld (stage_vld),
   .done      (done),
   .hi_we     (hi_we),
   .hi_wdata  (hi_wdata),
   .lo_we     (lo_we),
   .lo_wdata  (lo_wdata),
   .hi_out    (hi_out),
   .lo_out    (lo_out)
);

// File: tb/hilo_mac_tb_top.sv
`timescale 1ns/1ps
module hilo_mac_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  kind = 2'd0;
   logic        sgn = 1'b0;
   logic [31:0] a = '0;
   logic [31:0] b = '0;
   logic        hi_we = 1'b0;
   logic [31:0] hi_wdata = '0;
   logic        lo_we = 1'b0;
   logic [31:0] lo_wdata = '0;
   logic [63:0] hi_out;
   logic [63:0] lo_out;
   logic        done;

   int    checks = 0;
   int    errors = 0;
   string cur = "R1";
   bit    finished = 0;

   always #2.5 clk = ~clk;

   hilo_mac dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .sgn(sgn),
      .a(a), .b(b), .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we),
      .lo_wdata(lo_wdata), .hi_out(hi_out), .lo_out(lo_out), .done(done)
   );

   // behavioural reference model
   logic [31:0] m_hi, m_lo;
   logic        m_vld, m_done;
   logic [63:0] m_prod;
   logic [1:0]  m_kind;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hi = 0; m_lo = 0; m_vld = 0; m_done = 0; m_prod = 0; m_kind = 0;
      end else begin
         logic [63:0] acc, res, p;
         acc = {m_hi, m_lo};
         case (m_kind)
            2'd1:    res = acc + m_prod;
            2'd2:    res = acc - m_prod;
            default: res = m_prod;
         endcase
         if (sgn) p = 64'(longint'($signed(a)) * longint'($signed(b)));
         else     p = {32'h0, a} * {32'h0, b};
         m_done = m_vld;
         if (hi_we || lo_we) begin
            if (hi_we) m_hi = hi_wdata;
            if (lo_we) m_lo = lo_wdata;
         end else if (m_vld) begin
            m_hi = res[63:32];
            m_lo = res[31:0];
         end
         if (start && !m_vld) begin
            m_vld = 1; m_prod = p; m_kind = kind;
         end else begin
            m_vld = 0;
         end
      end
   end

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk(cur, "hi_out vs model", hi_out, {{32{m_hi[31]}}, m_hi});
         chk(cur, "lo_out vs model", lo_out, {{32{m_lo[31]}}, m_lo});
         chk(cur, "done vs model", {63'b0, done}, {63'b0, m_done});
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog expired in %s", cur);
      finish_run();
   end

   task automatic do_op(string tag, logic [1:0] k, logic s, logic [31:0] x, logic [31:0] y);
      cur = tag;
      @(negedge clk);
      start = 1; kind = k; sgn = s; a = x; b = y;
      @(negedge clk);
      chk("R6", "done one edge after start", {63'b0, done}, 64'd0);
      start = 0;
      @(negedge clk);
      chk("R6", "done two edges after start", {63'b0, done}, 64'd1);
   endtask

   task automatic wr(logic hw, logic [31:0] hd, logic lw, logic [31:0] ld);
      cur = "R8";
      @(negedge clk);
      hi_we = hw; hi_wdata = hd; lo_we = lw; lo_wdata = ld;
      @(negedge clk);
      hi_we = 0; lo_we = 0;
   endtask

   initial begin
      cur = "R1";
      #1;
      chk("R1", "hi in reset", hi_out, 64'd0);
      chk("R1", "done in reset", {63'b0, done}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "lo after reset", lo_out, 64'd0);

      do_op("R3", 2'd0, 1'b1, -32'sd3, 32'd7);
      chk("R3", "signed -3*7 hi", hi_out, 64'hFFFFFFFF_FFFFFFFF);
      chk("R2", "signed -3*7 lo", lo_out, 64'hFFFFFFFF_FFFFFFEB);
      do_op("R3", 2'd0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
      chk("R3", "unsigned max*max hi", hi_out, 64'hFFFFFFFF_FFFFFFFE);
      chk("R3", "unsigned max*max lo", lo_out, 64'h1);
      do_op("R3", 2'd0, 1'b1, 32'h80000000, 32'h80000000);
      chk("R3", "signed min*min hi", hi_out, 64'h40000000);
      chk("R10", "positive hi upper zero", hi_out[63:32], 64'h0);
      do_op("R2", 2'd3, 1'b0, 32'd3, 32'd5);
      chk("R2", "spare code hi", hi_out, 64'h0);
      chk("R2", "spare code lo", lo_out, 64'hF);

      wr(1, 32'hFFFFFFFF, 1, 32'hFFFFFFFF);
      chk("R8", "hi loaded", hi_out, 64'hFFFFFFFF_FFFFFFFF);
      do_op("R4", 2'd1, 1'b0, 32'd1, 32'd1);
      chk("R4", "madd wrap hi", hi_out, 64'h0);
      chk("R4", "madd wrap lo", lo_out, 64'h0);
      do_op("R5", 2'd2, 1'b1, 32'd1, 32'd1);
      chk("R5", "msub wrap hi", hi_out, 64'hFFFFFFFF_FFFFFFFF);
      chk("R10", "lo sign-extended", lo_out, 64'hFFFFFFFF_FFFFFFFF);
      do_op("R4", 2'd1, 1'b1, -32'sd2, 32'd3);
      chk("R4", "signed madd lo", lo_out, 64'hFFFFFFFF_FFFFFFF9);
      chk("R4", "signed madd hi", hi_out, 64'hFFFFFFFF_FFFFFFFF);

      wr(1, 32'h12345678, 1, 32'h9);
      chk("R8", "lo loaded", lo_out, 64'h9);
      do_op("R5", 2'd2, 1'b0, 32'd2, 32'h10);
      chk("R5", "msub borrow hi", hi_out, 64'h12345677);
      chk("R5", "msub borrow lo", lo_out, 64'hFFFFFFFF_FFFFFFE9);

      // R7: start held for a second cycle
      cur = "R7";
      @(negedge clk);
      start = 1; kind = 2'd0; sgn = 0; a = 32'd2; b = 32'd3;
      @(negedge clk);
      a = 32'd100; b = 32'd100;
      @(negedge clk);
      start = 0;
      chk("R7", "first result lo", lo_out, 64'd6);
      chk("R7", "done once", {63'b0, done}, 64'd1);
      @(negedge clk);
      chk("R7", "no second done", {63'b0, done}, 64'd0);
      chk("R7", "no second result", lo_out, 64'd6);

      // R9: direct write collides with completion
      cur = "R9";
      @(negedge clk);
      start = 1; kind = 2'd1; sgn = 0; a = 32'd1; b = 32'd1;
      @(negedge clk);
      start = 0; hi_we = 1; hi_wdata = 32'h0000ABCD;
      @(negedge clk);
      hi_we = 0;
      chk("R9", "write wins hi", hi_out, 64'hABCD);
      chk("R9", "lo keeps old value", lo_out, 64'd6);
      chk("R9", "done still pulses", {63'b0, done}, 64'd1);

      repeat (3) @(negedge clk);
      cur = "R6";
      chk("R6", "idle hold lo", lo_out, 64'd6);
      finish_run();
   end
endmodule